// File: doc/BRIEF.md
# Test-Mode Clock Divider Bank

This block drives seven output clock groups from one test clock, `clk_i`. Two mode pins choose how the groups behave. In the divide mode every group runs at a fixed integer ratio of the test clock, and all the ratios share one six-cycle frame. In the float mode every group enable is withdrawn, which models a high-impedance output. In the normal mode the block generates no clocks and only forwards, one cycle later, the output enables supplied from outside.

Each group has a fixed bit in `clk_o` and `oe_o`:

| Bit | Group |
|---|---|
| 0 | CPU |
| 1 | SDRAM/DCLK |
| 2 | 66 MHz fixed (3V66) |
| 3 | PCI |
| 4 | 48 MHz |
| 5 | reference |
| 6 | IOAPIC |

Mode pins are sampled on the rising edge of `clk_i`. A new mode is applied only at the boundary of a six-cycle frame. At that boundary every divided output is low, so a mode change never truncates a high pulse. Every divider restarts from the frame start, so the rising edges of all ratios coincide once every six cycles. The pins are a plain control interface with no handshake, and the block never stalls.

Top module: `tclk_div_bank`

## Requirements
- R1: With `test_ni`=0 and `sel0_i`=0 (float mode), `oe_o` is all zeros and every bit of `clk_o` is low.
- R2: In divide mode (`test_ni`=0, `sel0_i`=1), bits 0, 1 and 4 of `clk_o` run at the test clock divided by 2: high for one cycle, then low for one cycle, all three identical.
- R3: In divide mode, bit 2 runs at the test clock divided by 3: high for two cycles, then low for one.
- R4: In divide mode, bits 3 and 6 run at the test clock divided by 6: high for three cycles, then low for three, both identical.
- R5: Bit 5 repeats the test clock undivided while divide mode is in force, with whole high phases only. It is low in every other mode.
- R7: In normal mode (`test_ni`=1), every bit of `clk_o` is low and `oe_o` equals `ext_en_i` as sampled at the previous rising edge.
- R8: On entry to divide mode, all dividers start together. In the first cycle after entry every divided output is high, and the rising edges of all ratios coincide every six cycles.
- R9: A pin change is registered on the next rising edge. It takes effect at the first edge after which the six-cycle frame is complete, so no divided output ever shows a high pulse shorter than its nominal width.
- R10: While divide mode is in force, `oe_o` is all ones.
- R11: While `rst_ni` is low, `oe_o` is all zeros, `clk_o` is all low, and the block holds the float mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock, the source of all divided outputs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_ni | input | 1 | Test-mode select, active low |
| sel0_i | input | 1 | In test mode: 1 selects divide mode, 0 selects float mode |
| ext_en_i | input | 7 | Group enables forwarded to `oe_o` in normal mode |
| clk_o | output | 7 | Group clocks, one bit per group (bit map above) |
| oe_o | output | 7 | Group output enables; 0 models high impedance |

## Verification
From an idle mode (float or normal), a pin change is taken up at the first rising edge and applied at the second. The divided outputs and the enables therefore show the new mode from the second edge onward, and the bench samples them a nanosecond after each following falling edge. It samples the undivided reference bit a nanosecond after the rising edge, because its enable is updated on the falling edge. When the bench changes the pins while a frame is running, it counts the remaining edges of that frame before it expects the switch. In normal mode it expects each enable change one edge later.

// File: rtl/tdb_pkg.sv
package tdb_pkg;
  localparam int NGRP   = 7;
  localparam int PERIOD = 6;
  localparam int PH_W   = $clog2(PERIOD);

  localparam int IDX_CPU = 0;
  localparam int IDX_SDR = 1;
  localparam int IDX_V66 = 2;
  localparam int IDX_PCI = 3;
  localparam int IDX_M48 = 4;
  localparam int IDX_REF = 5;
  localparam int IDX_IOA = 6;

  typedef enum logic [1:0] {
    MODE_FLOAT = 2'd0,
    MODE_DIV   = 2'd1,
    MODE_NORM  = 2'd2
  } mode_e;

  // Division ratio of each group; 1 means the undivided test clock.
  function automatic int grp_ratio(input int g);
    case (g)
      IDX_CPU, IDX_SDR, IDX_M48: return 2;
      IDX_V66:                   return 3;
      IDX_PCI, IDX_IOA:          return 6;
      default:                   return 1;
    endcase
  endfunction

  function automatic mode_e decode_mode(input logic test_n, input logic sel0);
    if (test_n) return MODE_NORM;
    return sel0 ? MODE_DIV : MODE_FLOAT;
  endfunction
endpackage

// File: rtl/tdb_mode_ctrl.sv
module tdb_mode_ctrl
  import tdb_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            test_ni,
  input  logic            sel0_i,
  input  logic [NGRP-1:0] ext_en_i,
  input  logic            frame_end_i,
  output mode_e           act_q_o,
  output mode_e           act_n_o,
  output logic [NGRP-1:0] oe_o
);
  mode_e req_q;
  mode_e act_q;
  mode_e act_n;

  // A requested mode is adopted only at a frame boundary.
  assign act_n = frame_end_i ? req_q : act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= MODE_FLOAT;
      act_q <= MODE_FLOAT;
      oe_o  <= '0;
    end else begin
      req_q <= decode_mode(test_ni, sel0_i);
      act_q <= act_n;
      case (act_n)
        MODE_DIV:  oe_o <= '1;
        MODE_NORM: oe_o <= ext_en_i;
        default:   oe_o <= '0;
      endcase
    end
  end

  assign act_q_o = act_q;
  assign act_n_o = act_n;
endmodule

// File: rtl/tdb_phase_gen.sv
module tdb_phase_gen
  import tdb_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  mode_e           act_n_i,
  output logic [PH_W-1:0] ph_n_o,
  output logic            frame_end_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_n;

  // Outside divide mode the phase parks on the last slot, where every
  // divided output is low; the next divide frame then starts at slot 0.
  always_comb begin
    if (act_n_i != MODE_DIV)  ph_n = LAST;
    else if (ph_q == LAST)    ph_n = '0;
    else                      ph_n = ph_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= LAST;
    else         ph_q <= ph_n;
  end

  assign ph_n_o      = ph_n;
  assign frame_end_o = (ph_q == LAST);
endmodule

// File: rtl/tdb_tap.sv
module tdb_tap
  import tdb_pkg::*;
#(
  parameter int RATIO = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PH_W-1:0] ph_n_i,
  output logic            clk_o
);
  localparam int HI_LEN = RATIO - RATIO / 2;

  logic hit;
  assign hit = (int'(ph_n_i) % RATIO) < HI_LEN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_o <= 1'b0;
    else         clk_o <= hit;
  end
endmodule

// File: rtl/tdb_ref_gate.sv
module tdb_ref_gate
  import tdb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e act_q_i,
  output logic  clk_o
);
  logic en_q;

  // Enable changes while the clock is low, so only whole high phases pass.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= (act_q_i == MODE_DIV);
  end

  assign clk_o = clk_i & en_q;
endmodule

// File: rtl/tclk_div_bank.sv
module tclk_div_bank
  import tdb_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            test_ni,
  input  logic            sel0_i,
  input  logic [NGRP-1:0] ext_en_i,
  output logic [NGRP-1:0] clk_o,
  output logic [NGRP-1:0] oe_o
);
  mode_e           act_q;
  mode_e           act_n;
  logic [PH_W-1:0] ph_n;
  logic            frame_end;

  tdb_mode_ctrl u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .test_ni     (test_ni),
    .sel0_i      (sel0_i),
    .ext_en_i    (ext_en_i),
    .frame_end_i (frame_end),
    .act_q_o     (act_q),
    .act_n_o     (act_n),
    .oe_o        (oe_o)
  );

  tdb_phase_gen u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_n_i     (act_n),
    .ph_n_o      (ph_n),
    .frame_end_o (frame_end)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    if (grp_ratio(g) == 1) begin : g_ref
      tdb_ref_gate u_ref (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .act_q_i (act_q),
        .clk_o   (clk_o[g])
      );
    end else begin : g_div
      tdb_tap #(.RATIO(grp_ratio(g))) u_tap (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ph_n_i (ph_n),
        .clk_o  (clk_o[g])
      );
    end
  end
endmodule

// File: rtl/tdb_checker.sv
module tdb_checker
  import tdb_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NGRP-1:0] ext_en_i,
  input logic [NGRP-1:0] clk_o,
  input logic [NGRP-1:0] oe_o,
  input mode_e           act_q
);
  localparam logic [NGRP-1:0] DIVMASK = ~(NGRP'(1) << IDX_REF);

  AST_FLOAT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o == '0) |-> ((clk_o & DIVMASK) == '0)); // R1
  AST_DIV2_ALTERNATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_o[IDX_CPU] |=> !clk_o[IDX_CPU]); // R2
  AST_HALF_GROUP_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_o[IDX_CPU] == clk_o[IDX_SDR]) && (clk_o[IDX_CPU] == clk_o[IDX_M48])); // R2
  AST_DIV3_HIGH_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_o[IDX_V66]) |=> clk_o[IDX_V66]); // R3
  AST_DIV3_LOW_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_o[IDX_V66] && $past(clk_o[IDX_V66])) |=> !clk_o[IDX_V66]); // R3
  AST_DIV6_HIGH_THREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_o[IDX_PCI]) |-> ($past(clk_o[IDX_PCI], 2) && $past(clk_o[IDX_PCI], 3))); // R4
  AST_SLOW_GROUP_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_o[IDX_PCI] == clk_o[IDX_IOA]); // R4
  AST_EDGES_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_o[IDX_PCI]) |-> (clk_o[IDX_CPU] && clk_o[IDX_V66])); // R8
  AST_NORM_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == MODE_NORM) |-> (oe_o == $past(ext_en_i))); // R7
  AST_NORM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == MODE_NORM) |-> ((clk_o & DIVMASK) == '0)); // R7
  AST_DIV_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == MODE_DIV) |-> (oe_o == '1)); // R10
  AST_LEAVE_AT_FRAME_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(act_q) == MODE_DIV && act_q != MODE_DIV) |-> ($past(clk_o & DIVMASK) == '0)); // R9
endmodule

bind tclk_div_bank tdb_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ext_en_i (ext_en_i),
  .clk_o    (clk_o),
  .oe_o     (oe_o),
  .act_q    (act_q)
);

// File: tb/tclk_div_bank_tb.sv
module tclk_div_bank_tb;
  localparam int N = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         test_n = 1'b0;
  logic         sel0 = 1'b0;
  logic [N-1:0] ext_en = '0;
  logic [N-1:0] clk_o;
  logic [N-1:0] oe_o;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;

  // Group ratios as listed in the requirements (1 = undivided).
  int ratio [N] = '{2, 2, 3, 6, 2, 1, 6};

  always #2.5 clk = ~clk;

  tclk_div_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .test_ni(test_n), .sel0_i(sel0),
    .ext_en_i(ext_en), .clk_o(clk_o), .oe_o(oe_o)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] div_pattern(input int n);
    logic [N-1:0] v = '0;
    for (int g = 0; g < N; g++)
      if (ratio[g] > 1) v[g] = (n % ratio[g]) < (ratio[g] - ratio[g] / 2);
    return v;
  endfunction

  // Pulse-width monitor on the divided outputs (R9 / R2 / R3 / R4).
  int run [N];
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      for (int g = 0; g < N; g++) begin
        if (ratio[g] > 1) begin
          if (clk_o[g]) run[g]++;
          else if (run[g] > 0) begin
            check("R9 pulse width", N'(run[g]), N'(ratio[g] - ratio[g] / 2));
            run[g] = 0;
          end
        end
      end
    end else begin
      for (int g = 0; g < N; g++) run[g] = 0;
    end
  end

  task automatic settle_float();
    @(negedge clk);
    test_n = 1'b0; sel0 = 1'b0; ext_en = '0;
    repeat (10) @(negedge clk);
  endtask

  // Apply mode from an idle mode, then check 12 cycles at known latency.
  task automatic run_mode(input logic tn, input logic s0, input logic [N-1:0] pat);
    logic [N-1:0] exp_clk, exp_oe;
    logic         exp_ref;
    settle_float();
    test_n = tn; sel0 = s0; ext_en = pat;
    @(posedge clk); @(posedge clk);
    for (int n = 0; n < 12; n++) begin
      @(negedge clk); #1;
      if (tn) begin
        exp_clk = '0; exp_oe = pat; exp_ref = 1'b0;
        check("R7 normal clocks low", clk_o, exp_clk);
        check("R7 normal enables", oe_o, exp_oe);
      end else if (s0) begin
        exp_clk = div_pattern(n); exp_oe = '1; exp_ref = 1'b1;
        check("R2 R3 R4 R8 divide pattern", clk_o, exp_clk);
        check("R10 divide enables", oe_o, exp_oe);
      end else begin
        exp_clk = '0; exp_oe = '0; exp_ref = 1'b0;
        check("R1 float clocks", clk_o, exp_clk);
        check("R1 float enables", oe_o, exp_oe);
      end
      @(posedge clk); #1;
      check("R5 reference high phase", N'(clk_o[5]), N'(exp_ref));
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R11 reset clocks", clk_o, '0);
    check("R11 reset enables", oe_o, '0);
    ext_en = 7'h7F;
    @(negedge clk); #1;
    check("R11 reset ignores enables", oe_o, '0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // Sweep every mode with several enable patterns.
    for (int c = 0; c < 12; c++)
      run_mode(c % 3 == 2, c % 3 == 1, N'(c * 37 + 5));

    // Normal mode: exhaustive enable sweep, one edge of latency (R7).
    settle_float();
    test_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int v = 0; v < 128; v++) begin
      ext_en = N'(v);
      @(negedge clk); #1;
      check("R7 enable forward", oe_o, N'(v));
    end

    // Divide -> float requested mid-frame: switch waits for frame end (R9).
    settle_float();
    sel0 = 1'b1;
    @(posedge clk); @(posedge clk);
    for (int n = 0; n < 7; n++) begin
      @(negedge clk);
      if (n == 2) begin
        sel0 = 1'b0;
      end
      #1;
      if (n >= 3 && n <= 5) check("R9 divide held to frame end", oe_o, '1);
      if (n == 5) check("R9 all divided low at frame end", clk_o & 7'h5F, '0);
      if (n == 6) begin
        check("R9 float after frame end", oe_o, '0);
        check("R1 float clocks after switch", clk_o, '0);
      end
    end

    // Divide -> normal requested mid-frame (R9, R7).
    settle_float();
    sel0 = 1'b1;
    @(posedge clk); @(posedge clk);
    for (int n = 0; n < 7; n++) begin
      @(negedge clk);
      if (n == 4) begin
        test_n = 1'b1; ext_en = 7'h55;
      end
      #1;
      if (n == 5) check("R9 divide held to frame end", oe_o, '1);
      if (n == 6) begin
        check("R9 normal after frame end", oe_o, 7'h55);
        check("R7 normal clocks low after switch", clk_o, '0);
      end
    end

    // Re-entry into divide mode restarts aligned (R8).
    settle_float();
    sel0 = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); #1;
    check("R8 aligned restart", clk_o & 7'h5F, 7'h5F);

    settle_float();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule